// File: doc/BRIEF.md
# Register-Operand Data-Processing Unit with Shift Stage

This unit executes the register form of integer data-processing instructions on 32-bit values. It is given a complete instruction word together with the two source register values already read from the register file. It also receives the current flag nibble. The second operand first goes through a barrel shifter. The shift kind and the shift amount come from fields of the instruction word. The first operand and the shifted value then feed either an adder, which handles the subtract, reverse and carry-chained forms, or a bitwise unit.

The unit places the result, the destination index, a destination write strobe, a flag write strobe and the new flag nibble in one output register stage. The surrounding pipeline uses two combinational index outputs to address the register file. It commits the result and the flags when the strobes are high. Evaluation of the condition field and the register file itself belong to other blocks.

Top module: `dpAluCore`

## Requirements
- R1: While `rstN` is low, `outValid`, `destWrEn`, `flagsWrEn`, `result`, `destReg` and `flagsOut` are all zero.
- R2: Every output except the index pair appears one clock after the instruction is presented. `outValid` follows `inValid` with that delay. `destReg` carries instruction bits 15:12. `rnIdx` is bits 19:16 and `rmIdx` is bits 3:0, both combinational.
- R3: The op field is bits 24:20 and bit 20 is the flag-update bit. Upper op nibble 0100 adds, 0010 computes Rn minus operand, 0011 computes operand minus Rn, and 0101 adds plus carry. 0110 computes Rn minus operand minus the inverse of carry, and 0111 is the reversed form of 0110. In every subtract, C set means no borrow.
- R4: Upper op nibble 0000 gives AND, 0001 gives XOR, 1100 gives OR and 1110 gives Rn AND NOT operand. 1111 gives NOT operand and 1101 passes the operand through.
- R5: Op 10001 (AND test), 10011 (XOR test), 10101 (compare by subtract) and 10111 (compare by add) write flags and never assert `destWrEn`.
- R6: Bits 6:5 select the shift kind: 00 left, 01 logical right, 10 arithmetic right, 11 rotate. Bits 11:7 give the amount. A left shift by 0 leaves the operand and the carry as they are. A right shift with amount 0 shifts by 32. Every nonzero shift sets the shifter carry to the last bit shifted out, or to the new bit 31 for a rotate.
- R7: Rotate with amount 0 performs a one-bit rotate right through carry. The old C enters bit 31 and old bit 0 becomes the shifter carry.
- R8: N is result bit 31 and Z is set when the result is zero. For arithmetic ops, C is the adder carry out and V is the signed overflow. For bitwise ops, C is the shifter carry and V keeps its input value.
- R9: With the flag-update bit clear, `flagsWrEn` is 0 and `flagsOut` equals the `flagsIn` that was presented with the instruction. Flag order is {N,Z,C,V} from bit 3 down to bit 0.
- R10: Neither strobe is raised in four cases: `inValid` is low, bits 27:25 are not 000, bit 4 is 1 (register-amount shift), or the op field matches 10xx0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Instruction and operands present this cycle |
| instr | input | 32 | Instruction word |
| rnVal | input | 32 | First source register value |
| rmVal | input | 32 | Second source register value, before shifting |
| flagsIn | input | 4 | Current flags {N,Z,C,V} |
| rnIdx | output | 4 | First source register index |
| rmIdx | output | 4 | Second source register index |
| outValid | output | 1 | Registered results valid |
| result | output | 32 | Operation result |
| destReg | output | 4 | Destination register index |
| destWrEn | output | 1 | Write result to destination |
| flagsWrEn | output | 1 | Write new flags |
| flagsOut | output | 4 | New flags {N,Z,C,V} |

## Verification
The index outputs are combinational, so the bench checks them while the instruction is still driven. The result, the strobes, the destination index and the flags come out of a single register and are due one clock after the instruction. The bench drives each instruction on a falling edge, waits for the next rising edge and samples on the falling edge that follows. A second vector therefore never overlaps the one being checked. The embedded properties use the same one-cycle relation, expressed with `|=>` from the input side.

// File: rtl/dpAluPkg.sv
package dpAluPkg;
  localparam int INSTR_W = 32;

  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shiftKind_t;

  typedef enum logic [2:0] {
    LG_AND,
    LG_EOR,
    LG_ORR,
    LG_BIC,
    LG_PASS,
    LG_NOT
  } logicSel_t;

  typedef enum logic [1:0] {
    CIN_ZERO,
    CIN_ONE,
    CIN_FLAG
  } carrySel_t;

  typedef struct packed {
    logic       live;
    logic       useAdder;
    logic       swapOps;
    logic       invY;
    carrySel_t  cinSel;
    logicSel_t  logicSel;
    logic       wrDest;
    logic       wrFlags;
  } aluCtrl_t;
endpackage

// File: rtl/dpAluCtrl.sv
module dpAluCtrl
  import dpAluPkg::*;
(
  input  logic       inValid,
  input  logic [2:0] classBits,
  input  logic [4:0] opField,
  input  logic       regShift,
  output aluCtrl_t   ctrl
);
  logic isDataProc;
  logic isMisc;
  logic accept;
  logic destKind;

  assign isDataProc = (classBits == 3'b000) && !regShift;
  assign isMisc     = (opField[4:3] == 2'b10) && !opField[0];
  assign accept     = inValid && isDataProc && !isMisc;

  always_comb begin
    ctrl          = '0;
    ctrl.live     = inValid;
    ctrl.cinSel   = CIN_ZERO;
    ctrl.logicSel = LG_PASS;
    destKind      = 1'b1;
    case (opField[4:1])
      4'b0000: ctrl.logicSel = LG_AND;
      4'b0001: ctrl.logicSel = LG_EOR;
      4'b0010: begin ctrl.useAdder = 1'b1; ctrl.invY = 1'b1; ctrl.cinSel = CIN_ONE; end
      4'b0011: begin ctrl.useAdder = 1'b1; ctrl.invY = 1'b1; ctrl.swapOps = 1'b1; ctrl.cinSel = CIN_ONE; end
      4'b0100: ctrl.useAdder = 1'b1;
      4'b0101: begin ctrl.useAdder = 1'b1; ctrl.cinSel = CIN_FLAG; end
      4'b0110: begin ctrl.useAdder = 1'b1; ctrl.invY = 1'b1; ctrl.cinSel = CIN_FLAG; end
      4'b0111: begin ctrl.useAdder = 1'b1; ctrl.invY = 1'b1; ctrl.swapOps = 1'b1; ctrl.cinSel = CIN_FLAG; end
      4'b1000: begin ctrl.logicSel = LG_AND; destKind = 1'b0; end
      4'b1001: begin ctrl.logicSel = LG_EOR; destKind = 1'b0; end
      4'b1010: begin ctrl.useAdder = 1'b1; ctrl.invY = 1'b1; ctrl.cinSel = CIN_ONE; destKind = 1'b0; end
      4'b1011: begin ctrl.useAdder = 1'b1; destKind = 1'b0; end
      4'b1100: ctrl.logicSel = LG_ORR;
      4'b1101: ctrl.logicSel = LG_PASS;
      4'b1110: ctrl.logicSel = LG_BIC;
      4'b1111: ctrl.logicSel = LG_NOT;
      default: ctrl.logicSel = LG_PASS;
    endcase
    ctrl.wrDest  = accept && destKind;
    ctrl.wrFlags = accept && opField[0];
  end
endmodule

// File: rtl/dpAluShifter.sv
module dpAluShifter
  import dpAluPkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SHAMT_W = $clog2(DATA_W)
)(
  input  logic [DATA_W-1:0]  value,
  input  shiftKind_t         kind,
  input  logic [SHAMT_W-1:0] amt,
  input  logic               carryIn,
  output logic [DATA_W-1:0]  shifted,
  output logic               carryOut
);
  logic [SHAMT_W:0]  rightAmt;
  logic [SHAMT_W:0]  rotBack;
  logic [DATA_W:0]   extL;
  logic [DATA_W:0]   extR;
  logic [DATA_W:0]   extA;
  logic [DATA_W-1:0] rotVal;

  always_comb begin
    rightAmt = (amt == '0) ? DATA_W[SHAMT_W:0] : {1'b0, amt};
    rotBack  = DATA_W[SHAMT_W:0] - {1'b0, amt};
    extL     = {1'b0, value} << amt;
    extR     = {value, 1'b0} >> rightAmt;
    extA     = $signed({value, 1'b0}) >>> rightAmt;
    rotVal   = (value >> amt) | (value << rotBack);
    shifted  = value;
    carryOut = carryIn;
    case (kind)
      SH_LSL: if (amt != '0) begin shifted = extL[DATA_W-1:0]; carryOut = extL[DATA_W]; end
      SH_LSR: begin shifted = extR[DATA_W:1]; carryOut = extR[0]; end
      SH_ASR: begin shifted = extA[DATA_W:1]; carryOut = extA[0]; end
      SH_ROR: begin
        if (amt == '0) begin
          shifted  = {carryIn, value[DATA_W-1:1]};
          carryOut = value[0];
        end else begin
          shifted  = rotVal;
          carryOut = rotVal[DATA_W-1];
        end
      end
      default: shifted = value;
    endcase
  end
endmodule

// File: rtl/dpAluPath.sv
module dpAluPath
  import dpAluPkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SHAMT_W = $clog2(DATA_W)
)(
  input  logic               clk,
  input  logic               rstN,
  input  aluCtrl_t           ctrl,
  input  shiftKind_t         shiftKind,
  input  logic [SHAMT_W-1:0] shiftAmt,
  input  logic [3:0]         destIdx,
  input  logic [DATA_W-1:0]  rnVal,
  input  logic [DATA_W-1:0]  rmVal,
  input  logic [3:0]         flagsIn,
  output logic               outValid,
  output logic [DATA_W-1:0]  result,
  output logic [3:0]         destReg,
  output logic               destWrEn,
  output logic               flagsWrEn,
  output logic [3:0]         flagsOut
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] opB;
  logic              shC;
  logic [DATA_W-1:0] xOp;
  logic [DATA_W-1:0] yRaw;
  logic [DATA_W-1:0] yOp;
  logic              cin;
  logic [DATA_W:0]   sum;
  logic              arithV;
  logic [DATA_W-1:0] logicRes;
  logic [DATA_W-1:0] resNext;
  logic [3:0]        flagsNext;

  dpAluShifter #(.DATA_W(DATA_W)) shifterInst (
    .value    (rmVal),
    .kind     (shiftKind),
    .amt      (shiftAmt),
    .carryIn  (flagsIn[1]),
    .shifted  (opB),
    .carryOut (shC)
  );

  always_comb begin
    xOp  = ctrl.swapOps ? opB : rnVal;
    yRaw = ctrl.swapOps ? rnVal : opB;
    yOp  = ctrl.invY ? ~yRaw : yRaw;
    case (ctrl.cinSel)
      CIN_ONE:  cin = 1'b1;
      CIN_FLAG: cin = flagsIn[1];
      default:  cin = 1'b0;
    endcase
    sum    = {1'b0, xOp} + {1'b0, yOp} + {{DATA_W{1'b0}}, cin};
    arithV = (xOp[MSB] == yOp[MSB]) && (sum[MSB] != xOp[MSB]);
    case (ctrl.logicSel)
      LG_AND:  logicRes = rnVal & opB;
      LG_EOR:  logicRes = rnVal ^ opB;
      LG_ORR:  logicRes = rnVal | opB;
      LG_BIC:  logicRes = rnVal & ~opB;
      LG_NOT:  logicRes = ~opB;
      default: logicRes = opB;
    endcase
    resNext   = ctrl.useAdder ? sum[MSB:0] : logicRes;
    flagsNext = {resNext[MSB], (resNext == '0),
                 ctrl.useAdder ? sum[DATA_W] : shC,
                 ctrl.useAdder ? arithV : flagsIn[0]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      result    <= '0;
      destReg   <= '0;
      destWrEn  <= 1'b0;
      flagsWrEn <= 1'b0;
      flagsOut  <= '0;
    end else begin
      outValid  <= ctrl.live;
      result    <= resNext;
      destReg   <= destIdx;
      destWrEn  <= ctrl.wrDest;
      flagsWrEn <= ctrl.wrFlags;
      flagsOut  <= ctrl.wrFlags ? flagsNext : flagsIn;
    end
  end

  a_r8_nz_track: assert property (@(posedge clk) disable iff (!rstN)
    flagsWrEn |-> (flagsOut[3] == result[MSB]) && (flagsOut[2] == (result == '0)));

  a_r9_flags_held: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.live && !ctrl.wrFlags) |=> (flagsOut == $past(flagsIn)));

  a_r10_wr_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    (destWrEn || flagsWrEn) |-> outValid);
endmodule

// File: rtl/dpAluCore.sv
module dpAluCore
  import dpAluPkg::*;
#(
  parameter int DATA_W = 32
)(
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [INSTR_W-1:0]  instr,
  input  logic [DATA_W-1:0]   rnVal,
  input  logic [DATA_W-1:0]   rmVal,
  input  logic [3:0]          flagsIn,
  output logic [3:0]          rnIdx,
  output logic [3:0]          rmIdx,
  output logic                outValid,
  output logic [DATA_W-1:0]   result,
  output logic [3:0]          destReg,
  output logic                destWrEn,
  output logic                flagsWrEn,
  output logic [3:0]          flagsOut
);
  localparam int SHAMT_W = $clog2(DATA_W);

  aluCtrl_t ctrl;

  assign rnIdx = instr[19:16];
  assign rmIdx = instr[3:0];

  dpAluCtrl ctrlInst (
    .inValid   (inValid),
    .classBits (instr[27:25]),
    .opField   (instr[24:20]),
    .regShift  (instr[4]),
    .ctrl      (ctrl)
  );

  dpAluPath #(.DATA_W(DATA_W)) pathInst (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .shiftKind (shiftKind_t'(instr[6:5])),
    .shiftAmt  (instr[7 +: SHAMT_W]),
    .destIdx   (instr[15:12]),
    .rnVal     (rnVal),
    .rmVal     (rmVal),
    .flagsIn   (flagsIn),
    .outValid  (outValid),
    .result    (result),
    .destReg   (destReg),
    .destWrEn  (destWrEn),
    .flagsWrEn (flagsWrEn),
    .flagsOut  (flagsOut)
  );

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  a_r5_test_no_dest: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && instr[27:25] == 3'b000 && !instr[4] && instr[24:23] == 2'b10 && instr[20])
      |=> (flagsWrEn && !destWrEn));

  a_r10_reject: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (instr[27:25] != 3'b000 || instr[4])) |=> (!destWrEn && !flagsWrEn));
endmodule

// File: tb/dpAluCore_test.sv
`timescale 1ns/1ps
module dpAluCore_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] rnVal = '0;
  logic [31:0] rmVal = '0;
  logic [3:0]  flagsIn = '0;
  logic [3:0]  rnIdx, rmIdx, destReg, flagsOut;
  logic        outValid, destWrEn, flagsWrEn;
  logic [31:0] result;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dpAluCore uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .instr(instr),
    .rnVal(rnVal), .rmVal(rmVal), .flagsIn(flagsIn),
    .rnIdx(rnIdx), .rmIdx(rmIdx), .outValid(outValid), .result(result),
    .destReg(destReg), .destWrEn(destWrEn), .flagsWrEn(flagsWrEn), .flagsOut(flagsOut)
  );

  typedef struct packed {
    logic [4:0]  op;
    logic [4:0]  imm5;
    logic [1:0]  op2;
    logic [31:0] rn;
    logic [31:0] rm;
    logic [3:0]  fin;
    logic [31:0] expRes;
    logic        expWr;
    logic        expFw;
    logic [3:0]  expFlags;
  } vec_t;

  localparam int NVEC = 25;
  localparam vec_t VECS [NVEC] = '{
    '{5'b01001, 5'd0,  2'b00, 32'h1,        32'h2,        4'h0, 32'h3,        1'b1, 1'b1, 4'h0}, // R3 add
    '{5'b01001, 5'd0,  2'b00, 32'h7FFFFFFF, 32'h1,        4'h0, 32'h80000000, 1'b1, 1'b1, 4'h9}, // R8 overflow
    '{5'b01001, 5'd0,  2'b00, 32'hFFFFFFFF, 32'h1,        4'h0, 32'h0,        1'b1, 1'b1, 4'h6}, // R8 carry, zero
    '{5'b00101, 5'd0,  2'b00, 32'h5,        32'h5,        4'h0, 32'h0,        1'b1, 1'b1, 4'h6}, // R3 sub no borrow
    '{5'b00101, 5'd0,  2'b00, 32'h3,        32'h5,        4'h0, 32'hFFFFFFFE, 1'b1, 1'b1, 4'h8}, // R3 sub borrow
    '{5'b00111, 5'd0,  2'b00, 32'h3,        32'h5,        4'h0, 32'h2,        1'b1, 1'b1, 4'h2}, // R3 reverse sub
    '{5'b01011, 5'd0,  2'b00, 32'h1,        32'h2,        4'h2, 32'h4,        1'b1, 1'b1, 4'h0}, // R3 add with carry
    '{5'b01101, 5'd0,  2'b00, 32'hA,        32'h3,        4'h0, 32'h6,        1'b1, 1'b1, 4'h2}, // R3 sub with carry
    '{5'b01111, 5'd0,  2'b00, 32'h3,        32'hA,        4'h2, 32'h7,        1'b1, 1'b1, 4'h2}, // R3 reverse sub carry
    '{5'b00001, 5'd4,  2'b00, 32'hFFFFFFFF, 32'h1000000F, 4'h1, 32'hF0,       1'b1, 1'b1, 4'h3}, // R4 R6 R8 and, lsl 4
    '{5'b00010, 5'd0,  2'b00, 32'hFF,       32'h0F,       4'hA, 32'hF0,       1'b1, 1'b0, 4'hA}, // R4 R9 xor, no S
    '{5'b11001, 5'd0,  2'b01, 32'h0,        32'h80000000, 4'h0, 32'h0,        1'b1, 1'b1, 4'h6}, // R6 lsr 32
    '{5'b11101, 5'd0,  2'b00, 32'hFF,       32'h0F,       4'h2, 32'hF0,       1'b1, 1'b1, 4'h2}, // R4 bit clear
    '{5'b11111, 5'd0,  2'b00, 32'h0,        32'h0,        4'h0, 32'hFFFFFFFF, 1'b1, 1'b1, 4'h8}, // R4 not
    '{5'b11011, 5'd0,  2'b10, 32'h0,        32'h80000000, 4'h0, 32'hFFFFFFFF, 1'b1, 1'b1, 4'hA}, // R6 asr 32
    '{5'b11011, 5'd4,  2'b10, 32'h0,        32'h80000010, 4'h0, 32'hF8000001, 1'b1, 1'b1, 4'h8}, // R6 asr 4
    '{5'b11011, 5'd8,  2'b11, 32'h0,        32'h12345678, 4'h0, 32'h78123456, 1'b1, 1'b1, 4'h0}, // R6 ror 8
    '{5'b11011, 5'd0,  2'b11, 32'h0,        32'h3,        4'h2, 32'h80000001, 1'b1, 1'b1, 4'hA}, // R7 rrx
    '{5'b11011, 5'd1,  2'b01, 32'h0,        32'h3,        4'h0, 32'h1,        1'b1, 1'b1, 4'h2}, // R6 lsr 1
    '{5'b10101, 5'd0,  2'b00, 32'h5,        32'h7,        4'h0, 32'h0,        1'b0, 1'b1, 4'h8}, // R5 compare
    '{5'b10001, 5'd0,  2'b00, 32'hF0,       32'h0F,       4'h1, 32'h0,        1'b0, 1'b1, 4'h5}, // R5 R8 and test keeps V
    '{5'b10011, 5'd0,  2'b00, 32'h5,        32'h5,        4'h0, 32'h0,        1'b0, 1'b1, 4'h4}, // R5 xor test
    '{5'b10111, 5'd0,  2'b00, 32'hFFFFFFFF, 32'h1,        4'h0, 32'h0,        1'b0, 1'b1, 4'h6}, // R5 compare by add
    '{5'b11010, 5'd31, 2'b00, 32'h0,        32'h1,        4'h5, 32'h80000000, 1'b1, 1'b0, 4'h5}, // R6 R9 lsl 31, no S
    '{5'b00101, 5'd0,  2'b00, 32'h80000000, 32'h1,        4'h0, 32'h7FFFFFFF, 1'b1, 1'b1, 4'h3}  // R8 sub overflow
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkInstr(input logic [2:0] cls, input logic [4:0] op,
                                          input logic [4:0] imm5, input logic [1:0] op2,
                                          input logic bit4);
    return {4'hE, cls, op, 4'd1, 4'd4, imm5, op2, bit4, 4'd2};
  endfunction

  task automatic apply(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                       input logic [3:0] f, input logic v);
    @(negedge clk);
    instr = ins; rnVal = a; rmVal = b; flagsIn = f; inValid = v;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 outValid", {31'b0, outValid}, 32'h0);
    check("R1 destWrEn", {31'b0, destWrEn}, 32'h0);
    check("R1 flagsWrEn", {31'b0, flagsWrEn}, 32'h0);
    check("R1 result", result, 32'h0);
    check("R1 flags", {28'b0, flagsOut}, 32'h0);
    rstN = 1'b1;

    instr = mkInstr(3'b000, 5'b01001, 5'd0, 2'b00, 1'b0);
    #1;
    check("R2 rnIdx", {28'b0, rnIdx}, 32'h1);
    check("R2 rmIdx", {28'b0, rmIdx}, 32'h2);

    for (int i = 0; i < NVEC; i++) begin
      apply(mkInstr(3'b000, VECS[i].op, VECS[i].imm5, VECS[i].op2, 1'b0),
            VECS[i].rn, VECS[i].rm, VECS[i].fin, 1'b1);
      check($sformatf("R2 vec%0d outValid", i), {31'b0, outValid}, 32'h1);
      check($sformatf("R2 vec%0d destReg", i), {28'b0, destReg}, 32'h4);
      check($sformatf("R3-8 vec%0d destWrEn", i), {31'b0, destWrEn}, {31'b0, VECS[i].expWr});
      check($sformatf("R9 vec%0d flagsWrEn", i), {31'b0, flagsWrEn}, {31'b0, VECS[i].expFw});
      check($sformatf("R8 vec%0d flags", i), {28'b0, flagsOut}, {28'b0, VECS[i].expFlags});
      if (VECS[i].expWr)
        check($sformatf("R3-7 vec%0d result", i), result, VECS[i].expRes);
    end

    // R10: op field 10xx0 is not handled here
    apply(mkInstr(3'b000, 5'b10000, 5'd0, 2'b00, 1'b0), 32'h1, 32'h2, 4'h9, 1'b1);
    check("R10 misc destWrEn", {31'b0, destWrEn}, 32'h0);
    check("R10 misc flagsWrEn", {31'b0, flagsWrEn}, 32'h0);
    check("R10 misc flags", {28'b0, flagsOut}, 32'h9);

    // R10: other instruction class
    apply(mkInstr(3'b010, 5'b01001, 5'd0, 2'b00, 1'b0), 32'h1, 32'h2, 4'h0, 1'b1);
    check("R10 class destWrEn", {31'b0, destWrEn}, 32'h0);
    check("R10 class flagsWrEn", {31'b0, flagsWrEn}, 32'h0);

    // R10: register-amount shift form
    apply(mkInstr(3'b000, 5'b01001, 5'd0, 2'b00, 1'b1), 32'h1, 32'h2, 4'h0, 1'b1);
    check("R10 bit4 destWrEn", {31'b0, destWrEn}, 32'h0);
    check("R10 bit4 flagsWrEn", {31'b0, flagsWrEn}, 32'h0);

    // R10 and R2: no valid input
    apply(mkInstr(3'b000, 5'b01001, 5'd0, 2'b00, 1'b0), 32'h1, 32'h2, 4'h0, 1'b0);
    check("R2 idle outValid", {31'b0, outValid}, 32'h0);
    check("R10 idle destWrEn", {31'b0, destWrEn}, 32'h0);
    check("R10 idle flagsWrEn", {31'b0, flagsWrEn}, 32'h0);

    // R1: reset applied again after activity
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R1 rearm outValid", {31'b0, outValid}, 32'h0);
    check("R1 rearm destReg", {28'b0, destReg}, 32'h0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule